// File: doc/BRIEF.md
# Self-Detecting Multiplexed-Bus Write Register File

This block is the write-only host port of a peripheral that hangs on an 8-bit multiplexed address/data bus. The attached host can be of either of the two common multiplexed families: the one with an address-latch strobe and separate read and write strobes, or the one with an address strobe, a data strobe and a read/write direction line. The block works out which family is driving it afresh on every address strobe, so no strap pin or configuration step is needed.

Bytes land in a small bank of staging registers. Two further addresses carry no storage. A write to either of them copies the whole staging bank in one step into one of two 24-bit destination words: the run-time control word or the set-up word. The bus strobes are not related to the core clock. Each copy is handed to the core domain through a toggle flag and a two-flop synchroniser. The destination word and a one-cycle load pulse then appear together on the core side.

Top module: `mbr_regfile`

## Requirements
- R1: At each rising edge of `bus_ale` the level of `bus_rd_ds` selects the bus family for that bus cycle: high selects the strobe-pair family (writes on `bus_wr_rw` rising), low selects the direction-line family.
- R2: The register address is bits 2:0 of `bus_ad`, captured on the falling edge of `bus_ale`; bits 7:3 are ignored.
- R3: In the strobe-pair family a byte on `bus_ad` is stored on the rising edge of `bus_wr_rw`.
- R4: In the direction-line family a byte is stored on the falling edge of `bus_rd_ds` only when `bus_wr_rw` is low; with `bus_wr_rw` high the strobe stores nothing.
- R5: With `bus_cs_n` high at the write strobe, the write has no effect on any staging register or destination word.
- R6: A write to address 3 copies the staging bank to `ctl_word` as {stage2, stage1, stage0}, with stage0 (address 0) in bits 7:0 and stage2 (address 2) in bits 23:16; the data byte of that write is discarded.
- R7: A write to address 4 copies the staging bank to `ini_word` in the same byte order as R6; its data byte is discarded.
- R8: Writes to addresses 5, 6 and 7 change nothing. The staging registers keep their contents after a copy, so a second copy without new writes delivers the same word.
- R9: `ctl_word`/`ini_word` change only in the core cycle in which `ctl_load`/`ini_load` is high. Each pulse lasts one cycle, follows the copying strobe by at most 4 core cycles, and happens once per copy.
- R10: While `rst_n` is low, and after it rises, both words read zero and both load pulses are low until a copy occurs.
- R11: Consecutive bus cycles may alternate between the two bus families, and each one is handled by the family detected at its own address strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| bus_ad | input | 8 | Multiplexed address/data lines |
| bus_ale | input | 1 | Address strobe, active high |
| bus_rd_ds | input | 1 | Read strobe (strobe-pair family) or data strobe (direction-line family) |
| bus_wr_rw | input | 1 | Write strobe (strobe-pair family) or read/write direction (direction-line family, low = write) |
| bus_cs_n | input | 1 | Chip select, active low |
| ctl_word | output | 24 | Control destination word, core domain |
| ctl_load | output | 1 | One-cycle pulse when `ctl_word` takes a new copy |
| ini_word | output | 24 | Set-up destination word, core domain |
| ini_load | output | 1 | One-cycle pulse when `ini_word` takes a new copy |

## Verification
The two destination channels have separate synchronisers, so a set-up copy and a control copy can reach the core side in the same clock cycle. The bench provokes this with two complete bus cycles, a copy to address 4 and then one to address 3. Both are packed into a single core clock period, starting just after a rising edge. The scoreboard requires that both words carry the staged value, that both load pulses come in the same cycle, and that neither channel takes the other's word or loses its pulse.

// File: rtl/mbr_pkg.sv
`timescale 1ns/10ps
package mbr_pkg;
   typedef enum logic {
      MODE_DIRLINE = 1'b0,
      MODE_STRPAIR = 1'b1
   } bus_mode_e;

   localparam int DEST_CTL = 0;
   localparam int DEST_INI = 1;
   localparam int NUM_DEST = 2;
endpackage

// File: rtl/mbr_bus_strobe.sv
`timescale 1ns/10ps
module mbr_bus_strobe
   import mbr_pkg::*;
#(
   parameter int ADDR_W = 3
) (
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] ad_i,
   input  logic              ale_i,
   input  logic              rd_ds_i,
   input  logic              wr_rw_i,
   input  logic              cs_n_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic              wr_clk_o,
   output logic              wr_ok_o
);
   bus_mode_e mode_q;

   generate
      if (ADDR_W < 3) begin : g_bad_addr
         $error("mbr_bus_strobe: ADDR_W must reach the copy addresses");
      end
   endgenerate

   // family is re-detected on every address strobe
   always_ff @(posedge ale_i or negedge rst_n) begin
      if (!rst_n)       mode_q <= MODE_STRPAIR;
      else if (rd_ds_i) mode_q <= MODE_STRPAIR;
      else              mode_q <= MODE_DIRLINE;
   end

   always_ff @(negedge ale_i or negedge rst_n) begin
      if (!rst_n) addr_o <= '0;
      else        addr_o <= ad_i;
   end

   // one storing edge for both families: WR rising or DS falling
   always_comb begin
      if (mode_q == MODE_STRPAIR) wr_clk_o = wr_rw_i;
      else                        wr_clk_o = ~rd_ds_i;
   end

   // ale_i high masks the edge the mode switch itself can create
   always_comb begin
      wr_ok_o = !cs_n_i && !ale_i &&
                ((mode_q == MODE_STRPAIR) || !wr_rw_i);
   end
endmodule

// File: rtl/mbr_bus_port.sv
`timescale 1ns/10ps
module mbr_bus_port
   import mbr_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 3,
   parameter int NUM_TEMP = 3,
   localparam int WORD_W  = DATA_W * NUM_TEMP
) (
   input  logic              rst_n,
   input  logic              wr_clk_i,
   input  logic              wr_ok_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [NUM_DEST-1:0][WORD_W-1:0] hold_o,
   output logic [NUM_DEST-1:0]             tgl_o
);
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(NUM_TEMP);
   localparam logic [ADDR_W-1:0] INI_ADDR = ADDR_W'(NUM_TEMP + 1);

   logic [NUM_TEMP-1:0][DATA_W-1:0] stage_q;
   logic [WORD_W-1:0]               bank_w;

   generate
      if (NUM_TEMP + 2 > (1 << ADDR_W)) begin : g_bad_map
         $error("mbr_bus_port: address space too small for staging plus copy slots");
      end
      for (genvar gi = 0; gi < NUM_TEMP; gi++) begin : g_pack
         assign bank_w[gi*DATA_W +: DATA_W] = stage_q[gi];
      end
   endgenerate

   always_ff @(posedge wr_clk_i or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (wr_ok_i) begin
         for (int i = 0; i < NUM_TEMP; i++) begin
            if (addr_i == ADDR_W'(i)) stage_q[i] <= data_i;
         end
      end
   end

   // word and flag move on the same strobe; core samples the word later
   always_ff @(posedge wr_clk_i or negedge rst_n) begin
      if (!rst_n) begin
         hold_o <= '0;
         tgl_o  <= '0;
      end else if (wr_ok_i) begin
         if (addr_i == CTL_ADDR) begin
            hold_o[DEST_CTL] <= bank_w;
            tgl_o[DEST_CTL]  <= ~tgl_o[DEST_CTL];
         end else if (addr_i == INI_ADDR) begin
            hold_o[DEST_INI] <= bank_w;
            tgl_o[DEST_INI]  <= ~tgl_o[DEST_INI];
         end
      end
   end
endmodule

// File: rtl/mbr_xfer_sync.sv
`timescale 1ns/10ps
module mbr_xfer_sync #(
   parameter int WORD_W = 24,
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tgl_i,
   input  logic [WORD_W-1:0] hold_i,
   output logic [WORD_W-1:0] q_o,
   output logic              upd_o
);
   logic [STAGES-1:0] chain_q;
   logic              last_q;
   logic              edge_w;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("mbr_xfer_sync: at least two synchroniser stages required");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], tgl_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign edge_w = chain_q[STAGES-1] ^ last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o   <= '0;
         upd_o <= 1'b0;
      end else begin
         upd_o <= edge_w;
         if (edge_w) q_o <= hold_i;
      end
   end

   p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(q_o));
   p_load_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);
   p_hold_settled_r9: assert property (@(posedge clk) disable iff (!rst_n)
      edge_w |-> $stable(hold_i));
   p_word_matches_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |-> (q_o == hold_i));
endmodule

// File: rtl/mbr_regfile.sv
`timescale 1ns/10ps
module mbr_regfile
   import mbr_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int ADDR_W      = 3,
   parameter int NUM_TEMP    = 3,
   parameter int SYNC_STAGES = 2,
   localparam int WORD_W     = DATA_W * NUM_TEMP
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] bus_ad,
   input  logic              bus_ale,
   input  logic              bus_rd_ds,
   input  logic              bus_wr_rw,
   input  logic              bus_cs_n,
   output logic [WORD_W-1:0] ctl_word,
   output logic              ctl_load,
   output logic [WORD_W-1:0] ini_word,
   output logic              ini_load
);
   logic [ADDR_W-1:0]              addr_w;
   logic                           wr_clk_w;
   logic                           wr_ok_w;
   logic [NUM_DEST-1:0][WORD_W-1:0] hold_w;
   logic [NUM_DEST-1:0]            tgl_w;
   logic [NUM_DEST-1:0][WORD_W-1:0] word_w;
   logic [NUM_DEST-1:0]            load_w;

   generate
      if (ADDR_W > DATA_W) begin : g_bad_width
         $error("mbr_regfile: address wider than the shared lines");
      end
   endgenerate

   mbr_bus_strobe #(.ADDR_W(ADDR_W)) u_strobe (
      .rst_n    (rst_n),
      .ad_i     (bus_ad[ADDR_W-1:0]),
      .ale_i    (bus_ale),
      .rd_ds_i  (bus_rd_ds),
      .wr_rw_i  (bus_wr_rw),
      .cs_n_i   (bus_cs_n),
      .addr_o   (addr_w),
      .wr_clk_o (wr_clk_w),
      .wr_ok_o  (wr_ok_w)
   );

   mbr_bus_port #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_TEMP(NUM_TEMP)) u_port (
      .rst_n    (rst_n),
      .wr_clk_i (wr_clk_w),
      .wr_ok_i  (wr_ok_w),
      .addr_i   (addr_w),
      .data_i   (bus_ad),
      .hold_o   (hold_w),
      .tgl_o    (tgl_w)
   );

   generate
      for (genvar gd = 0; gd < NUM_DEST; gd++) begin : g_dest
         mbr_xfer_sync #(.WORD_W(WORD_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .tgl_i  (tgl_w[gd]),
            .hold_i (hold_w[gd]),
            .q_o    (word_w[gd]),
            .upd_o  (load_w[gd])
         );
      end
   endgenerate

   assign ctl_word = word_w[DEST_CTL];
   assign ctl_load = load_w[DEST_CTL];
   assign ini_word = word_w[DEST_INI];
   assign ini_load = load_w[DEST_INI];
endmodule

// File: tb/tb_mbr_regfile.sv
`timescale 1ns/10ps
module tb_mbr_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_ad = '0;
   logic        bus_ale = 1'b0;
   logic        bus_rd_ds = 1'b1;
   logic        bus_wr_rw = 1'b1;
   logic        bus_cs_n = 1'b1;
   logic [23:0] ctl_word, ini_word;
   logic        ctl_load, ini_load;

   int checks = 0;
   int fails = 0;
   int cyc = 0;
   bit run = 1'b0;
   int ctl_last = -1;
   int ini_last = -2;
   string cur_tag = "R0";

   logic [7:0]  m_stage [3];
   logic [23:0] ctl_val[$];
   int          ctl_cyc[$];
   string       ctl_tag[$];
   logic [23:0] ini_val[$];
   int          ini_cyc[$];
   string       ini_tag[$];

   mbr_regfile dut (
      .clk(clk), .rst_n(rst_n), .bus_ad(bus_ad), .bus_ale(bus_ale),
      .bus_rd_ds(bus_rd_ds), .bus_wr_rw(bus_wr_rw), .bus_cs_n(bus_cs_n),
      .ctl_word(ctl_word), .ctl_load(ctl_load),
      .ini_word(ini_word), .ini_load(ini_load)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag,
                        input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // scoreboard driver side: reference model of staging and copies
   task automatic model_write(input logic [7:0] a, input logic [7:0] d, input bit ok);
      if (ok) begin
         case (a[2:0])
            3'd0, 3'd1, 3'd2: m_stage[a[2:0]] = d;
            3'd3: begin
               ctl_val.push_back({m_stage[2], m_stage[1], m_stage[0]});
               ctl_cyc.push_back(cyc);
               ctl_tag.push_back(cur_tag);
            end
            3'd4: begin
               ini_val.push_back({m_stage[2], m_stage[1], m_stage[0]});
               ini_cyc.push_back(cyc);
               ini_tag.push_back(cur_tag);
            end
            default: ;
         endcase
      end
   endtask

   task automatic drive_pair(input logic [7:0] a, input logic [7:0] d,
                             input logic cs_n, input real st);
      bus_rd_ds = 1'b1; bus_wr_rw = 1'b1; #(st);
      bus_cs_n = cs_n; bus_ad = a; bus_ale = 1'b1; #(st);
      bus_ale = 1'b0; #(st);
      bus_ad = d; bus_wr_rw = 1'b0; #(st);
      bus_wr_rw = 1'b1; #(st);
      bus_cs_n = 1'b1;
      model_write(a, d, cs_n == 1'b0);
   endtask

   task automatic drive_dir(input logic [7:0] a, input logic [7:0] d,
                            input logic cs_n, input logic rw, input real st);
      bus_rd_ds = 1'b0; bus_wr_rw = rw; #(st);
      bus_cs_n = cs_n; bus_ad = a; bus_ale = 1'b1; #(st);
      bus_ale = 1'b0; #(st);
      bus_ad = d; bus_rd_ds = 1'b1; #(st);
      bus_rd_ds = 1'b0; #(st);
      bus_cs_n = 1'b1; bus_wr_rw = 1'b1;
      model_write(a, d, (cs_n == 1'b0) && (rw == 1'b0));
   endtask

   // scoreboard monitor side
   always @(negedge clk) begin
      if (rst_n && run) begin
         if (ctl_load) begin
            ctl_last = cyc;
            if (ctl_val.size() == 0) begin
               check(1'b0, "R9 spurious ctl_load", ctl_word, '0);
            end else begin
               check(ctl_word == ctl_val[0], ctl_tag[0], ctl_word, ctl_val[0]);
               check((cyc - ctl_cyc[0]) >= 2 && (cyc - ctl_cyc[0]) <= 4,
                     "R9 ctl latency", 24'(cyc - ctl_cyc[0]), 24'd3);
               void'(ctl_val.pop_front());
               void'(ctl_cyc.pop_front());
               void'(ctl_tag.pop_front());
            end
         end
         if (ini_load) begin
            ini_last = cyc;
            if (ini_val.size() == 0) begin
               check(1'b0, "R9 spurious ini_load", ini_word, '0);
            end else begin
               check(ini_word == ini_val[0], ini_tag[0], ini_word, ini_val[0]);
               check((cyc - ini_cyc[0]) >= 2 && (cyc - ini_cyc[0]) <= 4,
                     "R9 ini latency", 24'(cyc - ini_cyc[0]), 24'd3);
               void'(ini_val.pop_front());
               void'(ini_cyc.pop_front());
               void'(ini_tag.pop_front());
            end
         end
      end
   end

   initial begin
      repeat (40000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < 3; i++) m_stage[i] = 8'h00;
      repeat (3) @(negedge clk);
      check(ctl_word == 24'h0 && !ctl_load, "R10 ctl in reset", ctl_word, 24'h0);
      check(ini_word == 24'h0 && !ini_load, "R10 ini in reset", ini_word, 24'h0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(ctl_word == 24'h0 && !ctl_load, "R10 ctl after reset", ctl_word, 24'h0);
      check(ini_word == 24'h0 && !ini_load, "R10 ini after reset", ini_word, 24'h0);
      run = 1'b1;

      // R1 R3 R6: strobe-pair family, copy to control word
      cur_tag = "R3 R6 pair-family control copy";
      drive_pair(8'h00, 8'hA5, 1'b0, 3.0);
      drive_pair(8'h01, 8'h3C, 1'b0, 3.0);
      drive_pair(8'h02, 8'h96, 1'b0, 3.0);
      drive_pair(8'h03, 8'hFF, 1'b0, 3.0);
      repeat (8) @(negedge clk);

      // R4 R7 R11: direction-line family, copy to set-up word
      cur_tag = "R4 R7 R11 dir-family set-up copy";
      drive_dir(8'h00, 8'h11, 1'b0, 1'b0, 3.0);
      drive_dir(8'h01, 8'h22, 1'b0, 1'b0, 3.0);
      drive_dir(8'h02, 8'h33, 1'b0, 1'b0, 3.0);
      drive_dir(8'h04, 8'h5E, 1'b0, 1'b0, 3.0);
      repeat (8) @(negedge clk);

      // R5: deselected write leaves stage1 unchanged
      cur_tag = "R5 deselected write ignored";
      drive_pair(8'h01, 8'h77, 1'b1, 3.0);
      drive_pair(8'h03, 8'h00, 1'b0, 3.0);
      repeat (8) @(negedge clk);

      // R4 R8: read-direction strobe and unused addresses, then a copy without new writes
      cur_tag = "R4 R8 ignored writes and kept staging";
      drive_dir(8'h00, 8'hEE, 1'b0, 1'b1, 3.0);
      drive_dir(8'h05, 8'hFF, 1'b0, 1'b0, 3.0);
      drive_pair(8'h06, 8'hFF, 1'b0, 3.0);
      drive_pair(8'h07, 8'hFF, 1'b0, 3.0);
      drive_dir(8'h04, 8'h00, 1'b0, 1'b0, 3.0);
      repeat (8) @(negedge clk);

      // R2 R11: upper address bits ignored, families alternating
      cur_tag = "R2 R11 mixed families and address bits";
      drive_pair(8'hFA, 8'hC3, 1'b0, 3.0);
      drive_dir(8'hD8, 8'h5A, 1'b0, 1'b0, 3.0);
      drive_pair(8'hAB, 8'h01, 1'b0, 3.0);
      repeat (8) @(negedge clk);

      // R9 R6 R7: both copies inside one core period
      cur_tag = "R9 concurrent copies";
      @(posedge clk);
      #0.2;
      drive_pair(8'h04, 8'h00, 1'b0, 0.2);
      drive_pair(8'h03, 8'h00, 1'b0, 0.2);
      repeat (8) @(negedge clk);
      check(ctl_last == ini_last, "R9 concurrent loads same cycle",
            24'(ctl_last), 24'(ini_last));

      repeat (6) @(negedge clk);
      check(ctl_val.size() == 0, "R9 ctl copies all delivered", 24'(ctl_val.size()), 24'd0);
      check(ini_val.size() == 0, "R9 ini copies all delivered", 24'(ini_val.size()), 24'd0);

      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule